// File: doc/BRIEF.md
# Cross-Domain Timer Snapshot

This block runs a free-running binary counter on a slow clock and keeps an up-to-date copy of it in a faster clock domain that has no phase relationship to the slow one. Logic in the fast domain asks for a timestamp with a single-cycle request pulse. The block answers with the count and a one-cycle valid pulse on the next fast cycle. The fixed budget for this answer is four fast cycles, which is shorter than one slow period.

The slow clock is never used as a clock in the fast domain. Instead it is treated as data and shifted through a short synchronizer chain clocked by the fast clock. When the two oldest stages show a low-to-high change, the fast domain copies the counter into a holding register. At that point the slow-domain register has been stable for at least two fast cycles and will stay stable for the rest of the slow period. Because this copy is refreshed on every slow edge, a request can always be served straight from it. The method requires the fast clock to run at least about four times faster than the slow clock.

Top module: `tstamp_xing`

## Requirements
- R1: The counter resets to 0 and advances by one on every slow rising edge. It wraps modulo 2^TW.
- R2: The holding copy takes the counter value on the third fast rising edge after a slow rising edge. A request sampled on the first three fast edges after a slow edge therefore gets the previous count. A request sampled on the fourth edge or later gets the new count.
- R3: The holding copy changes only on a capture cycle.
- R4: Once at least one capture has happened, a request sampled on a fast edge raises stamp_vld on that same edge's register update, which is one cycle later. This is well inside the four-cycle budget.
- R5: The returned value is the count at the moment the request is sampled, or one less (modulo 2^TW).
- R6: stamp_vld is a one-cycle pulse for an isolated request. stamp keeps its value whenever stamp_vld is low.
- R7: After the fast reset, stamp_vld stays low until the first capture. A request that arrives before then is answered on the first capture, with the value captured there.
- R8: While the fast reset is asserted, stamp is 0 and stamp_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk | input | 1 | Slow clock; drives the counter and is sampled as data by the fast domain |
| slow_rst_n | input | 1 | Active-low asynchronous reset for the slow domain |
| fast_clk | input | 1 | Fast clock for the requester |
| fast_rst_n | input | 1 | Active-low asynchronous reset for the fast domain |
| req | input | 1 | One-cycle timestamp request, synchronous to fast_clk |
| stamp | output | TW | Returned counter value |
| stamp_vld | output | 1 | One-cycle pulse marking a new stamp |

## Verification
The assertions check the following on every cycle:
- the counter steps by one per slow edge;
- the holding copy only moves on a capture, and a capture never repeats on consecutive cycles;
- a request after the first capture is answered on the next cycle with the held value;
- stamp never changes without stamp_vld;
- stamp_vld stays quiet before the first capture.

The bench scenarios are what show the rest. A request swept across every fast-cycle position within the slow period returns exactly the count that follows from the three-stage capture delay, including across counter wraps. They also show that an early request is served on the first capture, and that reset clears the outputs.

// File: rtl/tstamp_xing.sv
module tstamp_xing #(
  parameter int TW       = 32,
  parameter int SYNC_LEN = 3
) (
  input  logic          slow_clk,
  input  logic          slow_rst_n,
  input  logic          fast_clk,
  input  logic          fast_rst_n,
  input  logic          req,
  output logic [TW-1:0] stamp,
  output logic          stamp_vld
);

  localparam int OLD = SYNC_LEN - 1;
  localparam int NEW = SYNC_LEN - 2;

  logic [TW-1:0]       tick_q;
  logic [SYNC_LEN-1:0] smp_q;
  logic [TW-1:0]       hold_q;
  logic                have_q;
  logic                pend_q;
  logic                cap;

  always_ff @(posedge slow_clk or negedge slow_rst_n)
    if (!slow_rst_n) tick_q <= '0;
    else             tick_q <= tick_q + 1'b1;

  assign cap = smp_q[NEW] & ~smp_q[OLD];

  always_ff @(posedge fast_clk or negedge fast_rst_n)
    if (!fast_rst_n) begin
      smp_q     <= '1;
      hold_q    <= '0;
      have_q    <= 1'b0;
      pend_q    <= 1'b0;
      stamp     <= '0;
      stamp_vld <= 1'b0;
    end else begin
      smp_q     <= {smp_q[SYNC_LEN-2:0], slow_clk};
      stamp_vld <= 1'b0;
      if (cap) begin
        hold_q <= tick_q;
        have_q <= 1'b1;
      end
      if (have_q) begin
        if (req) begin
          stamp     <= hold_q;
          stamp_vld <= 1'b1;
        end
      end else if (cap && (pend_q || req)) begin
        stamp     <= tick_q;
        stamp_vld <= 1'b1;
        pend_q    <= 1'b0;
      end else if (req) begin
        pend_q <= 1'b1;
      end
    end

  p_tick_step_r1: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    1'b1 |=> tick_q == $past(tick_q) + 1'b1);

  p_cap_single_r2: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    cap |=> !cap);

  p_hold_only_on_cap_r3: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    !cap |=> $stable(hold_q));

  p_answer_next_r4: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    (req && have_q) |=> (stamp_vld && stamp == $past(hold_q)));

  p_vld_pulse_r6: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    (stamp_vld && !req) |=> !stamp_vld);

  p_stamp_steady_r6: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    !$stable(stamp) |-> stamp_vld);

  p_quiet_before_cap_r7: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    !have_q |-> !stamp_vld);

endmodule

// File: tb/tstamp_xing_bench.sv
`timescale 1ns/1ps
module tstamp_xing_bench;
  localparam int TW = 4;
  localparam int M  = 1 << TW;

  logic slow_clk = 0, fast_clk = 0, slow_rst_n = 0, fast_rst_n = 0, req = 0;
  logic [TW-1:0] stamp;
  logic          stamp_vld;

  int checks = 0, errors = 0;
  int cnt = 0, since = 0, snap_cnt = 0, snap_k = 0;
  bit done = 0;

  tstamp_xing #(.TW(TW)) u_tstamp_xing (
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .fast_clk(fast_clk),
    .fast_rst_n(fast_rst_n), .req(req), .stamp(stamp), .stamp_vld(stamp_vld));

  always #5 fast_clk = ~fast_clk;
  initial begin #1.7; forever #25 slow_clk = ~slow_clk; end

  always @(posedge slow_clk) begin
    if (slow_rst_n) cnt = cnt + 1; else cnt = 0;
    since = 0;
  end

  always @(posedge fast_clk) begin
    since = since + 1;
    if (req) begin snap_cnt = cnt; snap_k = since; end
  end

  function automatic int wrap(input int v);
    return ((v % M) + M) % M;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int waited, held, exp;
    repeat (3) @(negedge fast_clk);
    check(stamp_vld == 0, "R8 vld in reset", stamp_vld, 0);
    check(stamp == 0, "R8 stamp in reset", stamp, 0);
    @(negedge slow_clk); slow_rst_n = 1;
    repeat (2) @(negedge fast_clk);
    fast_rst_n = 1; req = 1;
    @(negedge fast_clk); req = 0;
    check(stamp_vld == 0, "R7 no answer before capture", stamp_vld, 0);
    waited = 0;
    while (!stamp_vld && waited < 20) begin @(negedge fast_clk); waited++; end
    check(stamp_vld == 1, "R7 early request answered", stamp_vld, 1);
    check(since == 3, "R7 R2 answer on capture cycle", since, 3);
    check(stamp == wrap(cnt), "R7 R1 captured value", stamp, wrap(cnt));
    @(negedge fast_clk);
    check(stamp_vld == 0, "R6 pulse ends", stamp_vld, 0);

    for (int i = 0; i < 40; i++) begin
      repeat (6) @(negedge fast_clk);
      req = 1;
      @(negedge fast_clk); req = 0;
      check(stamp_vld == 1, "R4 answer next cycle", stamp_vld, 1);
      exp = (snap_k >= 4) ? wrap(snap_cnt) : wrap(snap_cnt - 1);
      check(stamp == exp, "R2 R5 R1 stamp value", stamp, exp);
      held = stamp;
      @(negedge fast_clk);
      check(stamp_vld == 0, "R6 single pulse", stamp_vld, 0);
      check(stamp == held, "R6 stamp held", stamp, held);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule